// File: doc/BRIEF.md
# Two-Speed Audio Gain Limiter

This block is the digital gain-control engine of a speaker amplifier. Two detector flags reach it from the analog side. One reports that the output has gone above the selected constant-power threshold. The other reports clipping-type distortion. From these flags it keeps an attenuation code in half-decibel steps and passes that code to the gain stage. Attenuation grows quickly while distortion is present and slowly while only the power threshold is exceeded. When both flags are clear, the attenuation is released at a much slower rate back toward nominal gain.

All step rates come from one shared tick counter. A 1 MHz strobe drives it, and the period it uses depends on the current state. The default periods give a 10 dB rise in about 1.5 ms in the fast phase, a 3.5 dB rise in about 6 ms in the slow phase, and a full 13.5 dB recovery in about 280 ms. A 3-bit level select picks one of seven constant-power thresholds, from 1.2 W down to 0.6 W into 8 ohm. The chosen index and its value in milliwatts go out to the analog comparator.

The controller is a five-state machine:
- OFF (code 0): the block is disabled.
- IDLE (code 1): no attenuation and no flag.
- FAST (code 2): distortion attack.
- SLOW (code 3): power-overshoot attack.
- RELEASE (code 4): recovery.

Transitions:
- Any state goes to OFF when enable is low.
- Any enabled state goes to FAST when distortion is flagged.
- Any enabled state goes to SLOW when only the power flag is set.
- Any enabled state goes to RELEASE when neither flag is set and attenuation is above zero.
- RELEASE goes to IDLE once attenuation reaches zero.
- A level-select change forces IDLE, or OFF if disabled.

Top module: `gain_limiter`

## Requirements
- R1: `atten_code` counts attenuation in 0.5 dB units, from 0 to 27 (13.5 dB). Further attack steps leave it at 27.
- R2: While enabled with `distort` high, `mode` is 2 (FAST). Each FAST_TICKS-th `tick_us` pulse counted in that state raises `atten_code` by one.
- R3: While enabled with only `over_pwr` high, `mode` is 3 (SLOW). Each SLOW_TICKS-th counted tick raises `atten_code` by one.
- R4: While enabled with both flags low and `atten_code` above 0, `mode` is 4 (RELEASE). Each REL_TICKS-th counted tick lowers `atten_code` by one. At 0 the state becomes 1 (IDLE).
- R5: With both flags high, the fast rate applies and `mode` is 2.
- R6: Any state change restarts the tick count. A tick sampled on the same edge as a state change is not counted, so a step needs a full period of ticks in one state.
- R7: `lvl_sel` value n from 0 to 6 gives `thr_idx` = n and `thr_mw` = 1200 − 100·n. The value 7 is treated as 6. Both outputs follow one clock after `lvl_sel`.
- R8: A change of `lvl_sel` clears `atten_code` to 0 on the next edge and restarts the tick count.
- R9: With `enable` low, `mode` is 0 (OFF) and `atten_code` is 0 from the next edge. No tick advances the count.
- R10: During and after reset, `atten_code` = 0, `mode` = 0, `thr_idx` = 0 and `thr_mw` = 1200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle 1 MHz timing strobe |
| enable | input | 1 | Limiter enable; low forces zero attenuation |
| lvl_sel | input | 3 | Constant-power level select |
| over_pwr | input | 1 | Output above the power threshold |
| distort | input | 1 | Clipping distortion detected |
| atten_code | output | 5 | Attenuation in 0.5 dB steps |
| mode | output | 3 | Controller state code (0 OFF, 1 IDLE, 2 FAST, 3 SLOW, 4 RELEASE) |
| thr_idx | output | 3 | Clamped threshold index for the comparator |
| thr_mw | output | 11 | Threshold power in milliwatts |

## Verification
Every result of this block is registered exactly once. A flag, enable or level change sampled on one rising edge shows up in `mode`, in `atten_code` and in the threshold outputs on that same edge. A rate step appears on the edge that samples the last tick of a period in an unchanged state. The bench drives inputs on falling edges and advances its reference model on each rising edge from the same sampled inputs. It compares the outputs on the following falling edge. Directed phases insert one idle cycle after each flag change, so that the state change and the counted ticks never share an edge, and then compare against step counts worked out by hand.

// File: rtl/lim_pkg.sv
package lim_pkg;

    // Controller state; the encoding is visible on the mode port.
    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_IDLE = 3'd1,
        ST_FAST = 3'd2,
        ST_SLOW = 3'd3,
        ST_REL  = 3'd4
    } lim_state_e;

    // Width of a counter that must hold values up to n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Largest of three tick periods.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/lim_level_map.sv
module lim_level_map #(
    parameter int LW      = 3,
    parameter int LEVELS  = 7,
    parameter int TOP_MW  = 1200,
    parameter int STEP_MW = 100,
    parameter int MW_W    = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   lvl_sel,
    output logic            lvl_chg,
    output logic [LW-1:0]   thr_idx,
    output logic [MW_W-1:0] thr_mw
);

    localparam logic [LW-1:0] LAST_IDX = LW'(LEVELS - 1);

    logic [LW-1:0]   lvl_q;
    logic [MW_W-1:0] mw_tab [LEVELS];

    // One threshold entry per selectable level.
    for (genvar g = 0; g < LEVELS; g++) begin : g_tab
        assign mw_tab[g] = MW_W'(TOP_MW - STEP_MW * g);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_sel;
        end
    end

    assign lvl_chg = (lvl_sel != lvl_q);

    always_comb begin
        if (lvl_q > LAST_IDX) begin
            thr_idx = LAST_IDX;
        end else begin
            thr_idx = lvl_q;
        end
        thr_mw = mw_tab[thr_idx];
    end

endmodule

// File: rtl/lim_step_timer.sv
module lim_step_timer #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic [CW-1:0] lim_last,
    output logic          step
);

    logic [CW-1:0] cnt_q;

    assign step = run && (cnt_q == lim_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == lim_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lim_atten_acc.sv
module lim_atten_acc #(
    parameter int AW        = 5,
    parameter int MAX_ATTEN = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic          dir_up,
    output logic [AW-1:0] atten,
    output logic          atten_nz
);

    localparam logic [AW-1:0] CAP = AW'(MAX_ATTEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            atten <= '0;
        end else if (clear) begin
            atten <= '0;
        end else if (step) begin
            if (dir_up) begin
                if (atten < CAP) atten <= atten + 1'b1;
            end else begin
                if (atten != '0) atten <= atten - 1'b1;
            end
        end
    end

    assign atten_nz = (atten != '0);

endmodule

// File: rtl/lim_fsm.sv
module lim_fsm
    import lim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       distort,
    input  logic       over_pwr,
    input  logic       lvl_chg,
    input  logic       atten_nz,
    input  logic       tick,
    output lim_state_e state_o,
    output logic       restart,
    output logic       run,
    output logic       clear_att,
    output logic       dir_up
);

    lim_state_e state_q;
    lim_state_e state_d;

    // Next-state decision: level change, then enable, then flags.
    always_comb begin
        if (lvl_chg) begin
            state_d = enable ? ST_IDLE : ST_OFF;
        end else if (!enable) begin
            state_d = ST_OFF;
        end else if (distort) begin
            state_d = ST_FAST;
        end else if (over_pwr) begin
            state_d = ST_SLOW;
        end else if (atten_nz) begin
            state_d = ST_REL;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs toward the timer and the accumulator.
    always_comb begin
        restart   = lvl_chg || (state_d != state_q);
        clear_att = lvl_chg || !enable;
        run       = 1'b0;
        dir_up    = 1'b1;
        unique case (state_q)
            ST_OFF:  run = 1'b0;
            ST_IDLE: run = 1'b0;
            ST_FAST: run = tick && !restart;
            ST_SLOW: run = tick && !restart;
            ST_REL: begin
                run    = tick && !restart;
                dir_up = 1'b0;
            end
            default: run = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/gain_limiter.sv
module gain_limiter
    import lim_pkg::*;
#(
    parameter int FAST_TICKS = 75,
    parameter int SLOW_TICKS = 857,
    parameter int REL_TICKS  = 10400,
    parameter int MAX_ATTEN  = 27,
    parameter int AW         = 5,
    parameter int LW         = 3,
    parameter int LEVELS     = 7,
    parameter int TOP_MW     = 1200,
    parameter int STEP_MW    = 100,
    parameter int MW_W       = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_us,
    input  logic            enable,
    input  logic [LW-1:0]   lvl_sel,
    input  logic            over_pwr,
    input  logic            distort,
    output logic [AW-1:0]   atten_code,
    output logic [2:0]      mode,
    output logic [LW-1:0]   thr_idx,
    output logic [MW_W-1:0] thr_mw
);

    localparam int CW = cnt_width(max3(FAST_TICKS, SLOW_TICKS, REL_TICKS));
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_TICKS - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_TICKS - 1);
    localparam logic [CW-1:0] REL_LAST  = CW'(REL_TICKS - 1);

    logic          lvl_chg;
    logic          atten_nz;
    logic          restart;
    logic          run;
    logic          clear_att;
    logic          dir_up;
    logic          step;
    logic [CW-1:0] lim_last;
    lim_state_e    state;

    lim_level_map #(
        .LW(LW), .LEVELS(LEVELS), .TOP_MW(TOP_MW),
        .STEP_MW(STEP_MW), .MW_W(MW_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .lvl_sel(lvl_sel),
        .lvl_chg(lvl_chg), .thr_idx(thr_idx), .thr_mw(thr_mw)
    );

    lim_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .distort(distort),
        .over_pwr(over_pwr), .lvl_chg(lvl_chg), .atten_nz(atten_nz),
        .tick(tick_us), .state_o(state), .restart(restart), .run(run),
        .clear_att(clear_att), .dir_up(dir_up)
    );

    // Tick period for the current rate state.
    always_comb begin
        unique case (state)
            ST_FAST: lim_last = FAST_LAST;
            ST_SLOW: lim_last = SLOW_LAST;
            default: lim_last = REL_LAST;
        endcase
    end

    lim_step_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
        .lim_last(lim_last), .step(step)
    );

    lim_atten_acc #(.AW(AW), .MAX_ATTEN(MAX_ATTEN)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(clear_att), .step(step),
        .dir_up(dir_up), .atten(atten_code), .atten_nz(atten_nz)
    );

    assign mode = state;

endmodule

// File: rtl/gain_limiter_chk.sv
module gain_limiter_chk #(
    parameter int MAX_ATTEN = 27,
    parameter int AW        = 5,
    parameter int LW        = 3,
    parameter int LEVELS    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          distort,
    input logic          over_pwr,
    input logic [LW-1:0] lvl_sel,
    input logic [AW-1:0] atten_code,
    input logic [2:0]    mode,
    input logic [LW-1:0] thr_idx
);

    logic [LW-1:0] prev_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_sel <= '0;
        else        prev_sel <= lvl_sel;
    end

    // R1
    atten_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        atten_code <= AW'(MAX_ATTEN));

    // R2
    rise_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (atten_code > $past(atten_code)) |->
        ((atten_code == AW'($past(atten_code) + 1'b1)) &&
         ($past(mode) == 3'd2 || $past(mode) == 3'd3)));

    // R4
    fall_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (atten_code < $past(atten_code)) |->
        ((atten_code == '0) ||
         ($past(mode) == 3'd4 && atten_code == AW'($past(atten_code) - 1'b1))));

    // R5
    fast_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && distort && over_pwr && lvl_sel == prev_sel) |=> (mode == 3'd2));

    // R8
    lvl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_sel != prev_sel) |=> (atten_code == '0));

    // R9
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (atten_code == '0 && mode == 3'd0));

    // R7
    thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_idx <= LW'(LEVELS - 1));

endmodule

bind gain_limiter gain_limiter_chk #(
    .MAX_ATTEN(MAX_ATTEN), .AW(AW), .LW(LW), .LEVELS(LEVELS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .distort(distort),
    .over_pwr(over_pwr), .lvl_sel(lvl_sel), .atten_code(atten_code),
    .mode(mode), .thr_idx(thr_idx)
);

// File: tb/gain_limiter_test.sv
module gain_limiter_test;

    localparam int FT   = 3;
    localparam int ST   = 5;
    localparam int RT   = 7;
    localparam int MAXA = 27;

    logic        clk = 1'b0;
    logic        rst_n, tick_us, enable, over_pwr, distort;
    logic [2:0]  lvl_sel;
    logic [4:0]  atten_code;
    logic [2:0]  mode;
    logic [2:0]  thr_idx;
    logic [10:0] thr_mw;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    bit cmp_on = 1'b0;

    int m_att, m_cnt, m_cls, m_lvl;

    always #5 clk = ~clk;

    gain_limiter #(.FAST_TICKS(FT), .SLOW_TICKS(ST), .REL_TICKS(RT)) uut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .enable(enable),
        .lvl_sel(lvl_sel), .over_pwr(over_pwr), .distort(distort),
        .atten_code(atten_code), .mode(mode), .thr_idx(thr_idx), .thr_mw(thr_mw)
    );

    function automatic int exp_mw(input int s);
        return 1200 - 100 * ((s > 6) ? 6 : s);
    endfunction

    function automatic string req_of(input int c);
        case (c)
            0: return "R9";
            2: return "R2";
            3: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin : model
        int nc, na, nn, lim;
        bit chg;
        if (!rst_n) begin
            m_att <= 0; m_cnt <= 0; m_cls <= 0; m_lvl <= 0;
        end else begin
            chg = (int'(lvl_sel) != m_lvl);
            na = m_att;
            nn = m_cnt;
            if (chg)              nc = enable ? 1 : 0;
            else if (!enable)     nc = 0;
            else if (distort)     nc = 2;
            else if (over_pwr)    nc = 3;
            else if (m_att != 0)  nc = 4;
            else                  nc = 1;
            if (chg || nc != m_cls) begin
                nn = 0;
            end else if (tick_us && nc >= 2) begin
                lim = (nc == 2) ? FT : (nc == 3) ? ST : RT;
                if (m_cnt == lim - 1) begin
                    nn = 0;
                    if (nc == 4) begin
                        if (na > 0) na--;
                    end else if (na < MAXA) begin
                        na++;
                    end
                end else begin
                    nn = m_cnt + 1;
                end
            end
            if (chg || !enable) na = 0;
            m_att <= na; m_cnt <= nn; m_cls <= nc; m_lvl <= int'(lvl_sel);
        end
    end

    // Continuous comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(req_of(m_cls), int'(atten_code), m_att);
            chk("R6", int'(mode), m_cls);
            chk("R7", int'(thr_mw), exp_mw(m_lvl));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tk(input int n);
        repeat (n) begin
            tick_us = 1'b1; @(negedge clk);
            tick_us = 1'b0; @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin : stim
        void'($urandom(32'd4321));
        rst_n = 1'b0; tick_us = 1'b0; enable = 1'b0;
        over_pwr = 1'b0; distort = 1'b0; lvl_sel = 3'd0;
        idle(3);
        chk("R10", int'(atten_code), 0);
        chk("R10", int'(mode), 0);
        chk("R10", int'(thr_idx), 0);
        chk("R10", int'(thr_mw), 1200);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle(1);
        enable = 1'b1; idle(1);
        chk("R4", int'(mode), 1);

        // R6: switching state before a period completes loses the ticks
        distort = 1'b1; idle(1); tk(2);
        distort = 1'b0; over_pwr = 1'b1; idle(1); tk(2);
        chk("R6", int'(atten_code), 0);
        distort = 1'b1; idle(1); tk(2);
        chk("R6", int'(atten_code), 0);
        tk(1);
        chk("R2", int'(atten_code), 1);
        chk("R5", int'(mode), 2);
        tk(FT * 30);
        chk("R1", int'(atten_code), MAXA);
        distort = 1'b0; idle(1); tk(ST * 2);
        chk("R1", int'(atten_code), MAXA);
        over_pwr = 1'b0; idle(1); tk(RT);
        chk("R4", int'(atten_code), MAXA - 1);
        chk("R4", int'(mode), 4);
        tk(RT * 26); idle(1);
        chk("R4", int'(atten_code), 0);
        chk("R4", int'(mode), 1);

        over_pwr = 1'b1; idle(1); tk(ST - 1);
        chk("R3", int'(atten_code), 0);
        tk(1);
        chk("R3", int'(atten_code), 1);

        enable = 1'b0; idle(1);
        chk("R9", int'(atten_code), 0);
        chk("R9", int'(mode), 0);
        distort = 1'b1; tk(10);
        chk("R9", int'(atten_code), 0);
        distort = 1'b0;
        enable = 1'b1; idle(1); tk(ST);
        chk("R3", int'(atten_code), 1);

        lvl_sel = 3'd3; idle(1);
        chk("R8", int'(atten_code), 0);
        chk("R7", int'(thr_idx), 3);
        chk("R7", int'(thr_mw), 900);
        over_pwr = 1'b0;
        for (int s = 0; s < 8; s++) begin
            lvl_sel = 3'(s); idle(1);
            chk("R7", int'(thr_idx), (s > 6) ? 6 : s);
            chk("R7", int'(thr_mw), exp_mw(s));
        end
        lvl_sel = 3'd2; idle(2);

        // Random phase against the reference model
        for (int seg = 0; seg < 3000; seg++) begin
            int r, len;
            r = int'($urandom % 10);
            distort  = (r < 2);
            over_pwr = (r >= 1 && r < 6);
            if ($urandom % 30 == 0) enable = 1'b0;
            else enable = 1'b1;
            if ($urandom % 40 == 0) lvl_sel = 3'($urandom % 8);
            len = 1 + int'($urandom % 30);
            for (int c = 0; c < len; c++) begin
                tick_us = ($urandom % 2) == 1;
                @(negedge clk);
            end
        end
        tick_us = 1'b0;
        idle(2);
        report();
    end

endmodule